// File: doc/BRIEF.md
# Selectable Constellation Mapper

This block turns a stream of coded bits into complex baseband samples for a following transform stage. Bits arrive two at a time on a fixed 2-bit word, qualified by an input valid. A scheme select picks one of three mappings: binary phase keying (one bit per symbol), quadrature phase keying (two bits per symbol) or 16-point quadrature amplitude modulation (four bits per symbol). Each symbol leaves as one 16-bit word carrying signed in-phase and quadrature parts, qualified by an output valid pulse.

The input word is always two bits wide, but the three schemes consume one, two and four bits per symbol. The block therefore drops the spare bit in the one-bit scheme, maps each word straight through in the two-bit scheme, and pairs consecutive words in the four-bit scheme. A flush strobe ends a 16-point stream that stops on an odd word. While half a pair is held, the scheme select is not looked at, so a scheme change takes effect only when no bits are pending.

Top module: `const_mapper`

## Requirements
- R1: After reset `out_valid` is 0 and `out_sample` is 16'h0000.
- R2: `out_sample[15:8]` holds the in-phase value and `out_sample[7:0]` the quadrature value, both 8-bit two's complement. The full-scale amplitude A is the parameter `AMP` (default 96), and the inner 16-point level is AMP/3 (default 32).
- R3: With `scheme` = 2'd0 (one bit per symbol), each valid word gives one symbol. Bit 0 equal to 0 gives I = +A and equal to 1 gives I = -A. Q is 0, and bit 1 has no effect on the output.
- R4: With `scheme` = 2'd1 (two bits per symbol), each valid word gives one symbol. Bit 0 sets I and bit 1 sets Q, with 0 giving +A and 1 giving -A.
- R5: With `scheme` = 2'd2 (16-point), two valid words form one symbol. Bits 0 and 1 of the first word are b0 and b1, and bits 0 and 1 of the second word are b2 and b3. The pair (b0,b1) sets I and the pair (b2,b3) sets Q, on the Gray sequence 00 to +A, 01 to +A/3, 11 to -A/3 and 10 to -A.
- R6: `out_valid` is high for exactly one cycle, in the cycle after the clock edge that captured the last input word of the symbol. The first word of a 16-point pair produces no output.
- R7: A `flush` with no valid input while one 16-point word is pending fills b2 and b3 with zeros and emits the symbol with the R6 timing. A `flush` with nothing pending produces no output.
- R8: While a 16-point word is pending, changes on `scheme` are ignored until the pair is completed or flushed.
- R9: `scheme` = 2'd3 behaves as scheme 2'd0.
- R10: When `out_valid` is low, `out_sample` keeps the last symbol emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scheme | input | 2 | 0 and 3: one bit per symbol; 1: two bits; 2: 16-point |
| in_valid | input | 1 | Qualifies `in_bits` |
| in_bits | input | 2 | Coded bit pair |
| flush | input | 1 | Emits a pending half 16-point pair, padded with zeros |
| out_valid | output | 1 | One-cycle strobe for `out_sample` |
| out_sample | output | 16 | {I[7:0], Q[7:0]} |

## Verification
The bench walks all sixteen 16-point bit combinations. A design that swaps the order of the pair, or uses natural binary levels in place of Gray levels, would put the inner and outer levels or the I and Q parts in the wrong places. It also checks that the first word of a pair stays silent, because a design that does not count words would emit half-built symbols every cycle. It flushes an odd word and an empty state: a wrong pad value shifts Q away from +A, and a flush that is not gated on a pending word makes spurious pulses. It changes the scheme between the two words of a pair and uses the spare bit in the one-bit scheme, where a design that follows the live select or reads bit 1 would give a wrong I or a non-zero Q.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        SCH_BIT1  = 2'd0,
        SCH_BIT2  = 2'd1,
        SCH_BIT4  = 2'd2,
        SCH_SPARE = 2'd3
    } scheme_e;

    // Spare code falls back to the one-bit scheme (R9).
    function automatic scheme_e scheme_decode(input logic [1:0] raw);
        scheme_e s;
        case (raw)
            2'd1:    s = SCH_BIT2;
            2'd2:    s = SCH_BIT4;
            default: s = SCH_BIT1;
        endcase
        return s;
    endfunction

    // Symbol bits: [0] I sign, [1] I inner, [2] Q sign, [3] Q inner
    typedef struct packed {
        logic [3:0] bits;
        scheme_e    scheme;
        logic       fire;
    } sym_t;

endpackage

// File: rtl/map_gather.sv
module map_gather
    import mapper_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] scheme_i,
    input  logic       in_valid_i,
    input  logic [1:0] in_bits_i,
    input  logic       flush_i,
    output sym_t       sym_o
);

    typedef struct packed {
        logic       pend;
        logic [1:0] half;
        scheme_e    act;
    } gst_t;

    gst_t    st_d, st_q;
    sym_t    sym;
    scheme_e eff;

    always_comb begin
        st_d       = st_q;
        eff        = st_q.pend ? st_q.act : scheme_decode(scheme_i);
        sym.fire   = 1'b0;
        sym.bits   = 4'b0000;
        sym.scheme = eff;
        if (!st_q.pend) begin
            st_d.act = eff;
        end
        if (in_valid_i) begin
            case (eff)
                SCH_BIT2: begin
                    sym.fire = 1'b1;
                    sym.bits = {1'b0, in_bits_i[1], 1'b0, in_bits_i[0]};
                end
                SCH_BIT4: begin
                    if (!st_q.pend) begin
                        st_d.pend = 1'b1;
                        st_d.half = in_bits_i;
                    end else begin
                        sym.fire  = 1'b1;
                        sym.bits  = {in_bits_i, st_q.half};
                        st_d.pend = 1'b0;
                    end
                end
                default: begin
                    sym.fire = 1'b1;
                    sym.bits = {3'b000, in_bits_i[0]};
                end
            endcase
        end else if (flush_i && st_q.pend) begin
            sym.fire  = 1'b1;
            sym.bits  = {2'b00, st_q.half};
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, half: 2'b00, act: SCH_BIT1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_o = sym;

    // R8: the latched scheme does not move while half a pair waits
    p_scheme_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !sym.fire) |=> (st_q.pend && $stable(st_q.act)));

    // R5: a pending word only exists in the 16-point scheme
    p_pend_only_qam_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (st_q.act == SCH_BIT4));

endmodule

// File: rtl/map_level.sv
module map_level #(
    parameter int W   = 8,
    parameter int AMP = 96
) (
    input  logic                sign_i,
    input  logic                inner_i,
    input  logic                four_i,
    input  logic                zero_i,
    output logic signed [W-1:0] lvl_o
);

    localparam logic signed [W-1:0] OUTER = W'(AMP);
    localparam logic signed [W-1:0] INNER = W'(AMP / 3);

    logic signed [W-1:0] mag;

    always_comb begin
        mag = (four_i && inner_i) ? INNER : OUTER;
        if (zero_i) begin
            lvl_o = '0;
        end else if (sign_i) begin
            lvl_o = -mag;
        end else begin
            lvl_o = mag;
        end
    end

endmodule

// File: rtl/const_mapper.sv
module const_mapper
    import mapper_pkg::*;
#(
    parameter int W   = 8,
    parameter int AMP = 96
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     scheme,
    input  logic           in_valid,
    input  logic [1:0]     in_bits,
    input  logic           flush,
    output logic           out_valid,
    output logic [2*W-1:0] out_sample
);

    localparam int SW = 2 * W;
    localparam logic [W-1:0] L_OUT = W'(AMP);
    localparam logic [W-1:0] L_IN  = W'(AMP / 3);

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] smp;
    } ost_t;

    sym_t         sym;
    ost_t         o_d, o_q;
    logic [W-1:0] lvl [2];

    map_gather u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .scheme_i   (scheme),
        .in_valid_i (in_valid),
        .in_bits_i  (in_bits),
        .flush_i    (flush),
        .sym_o      (sym)
    );

    // axis 0 = I, axis 1 = Q
    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        logic signed [W-1:0] lv;
        map_level #(.W(W), .AMP(AMP)) u_level (
            .sign_i  (sym.bits[2*ax]),
            .inner_i (sym.bits[2*ax+1]),
            .four_i  (sym.scheme == SCH_BIT4),
            .zero_i  ((ax == 1) && (sym.scheme == SCH_BIT1)),
            .lvl_o   (lv)
        );
        assign lvl[ax] = lv;
    end

    always_comb begin
        o_d     = o_q;
        o_d.vld = sym.fire;
        if (sym.fire) begin
            o_d.smp = {lvl[0], lvl[1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid  = o_q.vld;
    assign out_sample = o_q.smp;

    // R6: every output pulse follows a captured word or flush
    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid || flush));

    // R10: with no new symbol the sample holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sym.fire |=> $stable(out_sample));

    // R3: one-bit scheme leaves Q at zero
    p_bpsk_q_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym.fire && sym.scheme == SCH_BIT1) |=> (out_sample[W-1:0] == '0));

    // R2: I always lands on one of the legal levels
    p_i_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sample[SW-1:W] == L_OUT || out_sample[SW-1:W] == -L_OUT ||
                       out_sample[SW-1:W] == L_IN  || out_sample[SW-1:W] == -L_IN));

endmodule

// File: tb/const_mapper_tb.sv
`timescale 1ns/1ps
module const_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  scheme = 2'd0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_bits = 2'd0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic [15:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    const_mapper u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scheme     (scheme),
        .in_valid   (in_valid),
        .in_bits    (in_bits),
        .flush      (flush),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic logic [7:0] lv2(input logic b);
        return b ? 8'hA0 : 8'h60;
    endfunction

    function automatic logic [7:0] lv4(input logic s, input logic n);
        if (s) return n ? 8'hE0 : 8'hA0;
        return n ? 8'h20 : 8'h60;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the next negedge with outputs settled
    task automatic step(input logic [1:0] sch, input logic v, input logic [1:0] w, input logic fl);
        @(negedge clk);
        scheme   = sch;
        in_valid = v;
        in_bits  = w;
        flush    = fl;
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", {out_valid, out_sample}, 17'h0_0000);
    endtask

    task automatic t_bpsk();
        for (int w = 0; w < 4; w++) begin
            step(2'd0, 1'b1, 2'(w), 1'b0);
            // R3 and R2: I in high byte, Q zero, bit 1 ignored
            check("R3", {out_valid, out_sample}, {1'b1, lv2(w[0]), 8'h00});
        end
    endtask

    task automatic t_qpsk();
        for (int w = 0; w < 4; w++) begin
            step(2'd1, 1'b1, 2'(w), 1'b0);
            check("R4", {out_valid, out_sample}, {1'b1, lv2(w[0]), lv2(w[1])});
        end
    endtask

    task automatic t_qam();
        for (int c = 0; c < 16; c++) begin
            logic [3:0] b;
            b = 4'(c);
            step(2'd2, 1'b1, b[1:0], 1'b0);
            check("R6", {16'h0000, out_valid}, 17'h0);
            step(2'd2, 1'b1, b[3:2], 1'b0);
            check("R5", {out_valid, out_sample}, {1'b1, lv4(b[0], b[1]), lv4(b[2], b[3])});
            step(2'd2, 1'b0, 2'b00, 1'b0);
            check("R6", {16'h0000, out_valid}, 17'h0);
        end
    endtask

    task automatic t_flush();
        step(2'd2, 1'b1, 2'b11, 1'b0);
        check("R7", {16'h0000, out_valid}, 17'h0);
        step(2'd2, 1'b0, 2'b00, 1'b1);
        check("R7", {out_valid, out_sample}, {1'b1, 8'hE0, 8'h60});
        step(2'd2, 1'b0, 2'b00, 1'b1);
        check("R7", {out_valid, out_sample}, {1'b0, 8'hE0, 8'h60});
    endtask

    task automatic t_switch();
        step(2'd2, 1'b1, 2'b01, 1'b0);
        step(2'd0, 1'b1, 2'b10, 1'b0);
        // pair completes as 16-point despite select moved (R8)
        check("R8", {out_valid, out_sample}, {1'b1, lv4(1'b1, 1'b0), lv4(1'b0, 1'b1)});
        step(2'd0, 1'b1, 2'b01, 1'b0);
        check("R8", {out_valid, out_sample}, {1'b1, 8'hA0, 8'h00});
    endtask

    task automatic t_spare();
        step(2'd3, 1'b1, 2'b10, 1'b0);
        check("R9", {out_valid, out_sample}, {1'b1, 8'h60, 8'h00});
        step(2'd3, 1'b1, 2'b11, 1'b0);
        check("R9", {out_valid, out_sample}, {1'b1, 8'hA0, 8'h00});
    endtask

    task automatic t_hold();
        step(2'd1, 1'b1, 2'b10, 1'b0);
        check("R10", {out_valid, out_sample}, {1'b1, 8'h60, 8'hA0});
        for (int i = 0; i < 3; i++) begin
            step(2'd1, 1'b0, 2'b01, 1'b0);
            check("R10", {out_valid, out_sample}, {1'b0, 8'h60, 8'hA0});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bpsk();
        t_qpsk();
        t_qam();
        t_flush();
        t_switch();
        t_spare();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule